// File: doc/BRIEF.md
# System Tick Down-Counter Timer

A periodic down-counter for a microcontroller core, programmed through four word registers on a simple single-cycle bus port. Software loads a reload value, then turns the timer on. The counter steps down once per tick of the selected source. That source is either every core clock or an external reference tick-enable strobe. When the counter is at zero and a tick arrives, the timer reloads. It also sets a sticky count flag and, if allowed, raises a one-cycle interrupt-pending pulse.

The flag is cleared as a side effect of reading the control/status register, and also by any write to the current-value register. That write reloads the counter. A zero reload value makes the timer one-shot: the expiry turns the enable bit off. Disabling the timer pauses the count, and enabling it again resumes from the remaining value. Changing the tick source restarts the count from the reload value. Read data is combinational from the registered state. Read side effects and writes take place at the clock edge that ends the bus cycle.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset, the control/status, reload and current-value registers read 0, the calibration register reads the CALIB_VALUE parameter, and irq_pend is 0.
- R2: Control/status layout: bit 0 enable, bit 1 interrupt enable, bit 2 source select (1 = core clock, 0 = reference tick), bit 16 count flag, other bits read 0. A write changes only bits [2:0] and takes effect from the next cycle.
- R3: A read of control/status returns the value held before the edge and then clears the count flag. If an expiry happens in the same cycle, the flag ends up set.
- R4: While enabled, the counter steps down once per tick: every clock when source select is 1, and only in cycles where ref_tick_en is 1 when it is 0. One period lasts reload+1 ticks.
- R5: A tick with the counter at 0 is an expiry. The counter is reloaded and the count flag is set. If interrupt enable was 1, irq_pend is high for exactly the following cycle.
- R6: An expiry while the reload register holds 0 clears the enable bit, unless control is written in the same cycle.
- R7: Any write to the current-value register reloads the counter from the reload register and clears the count flag, whatever the data. In that cycle it overrides counting, so no expiry or pulse is produced.
- R8: The current value reads 0 while disabled. Clearing enable holds the count, and setting it again resumes from the held value. Enabling while the counter is 0 loads the reload value.
- R9: A control write that changes source select reloads the counter and suppresses any expiry in that cycle.
- R10: Reload and current values are CNT_W (24) bits wide. Upper bits read 0 and are ignored on write.
- R11: The calibration register is read-only. Writes to it have no effect.
- R12: Word offsets are 0x10 control/status, 0x14 reload, 0x18 current value and 0x1C calibration. Other offsets read 0 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick_en | input | 1 | Reference tick strobe, one clock wide per tick |
| bus_sel | input | 1 | Bus cycle valid this clock |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address of the word register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |
| irq_pend | output | 1 | One-cycle interrupt-pending pulse |

## Verification
The hardest cases to reach are the ones where a bus access falls on the very cycle of an expiry. Examples are a status read racing a new flag, and a current-value write racing a wrap. Reaching these by fixed delays would depend on exact cycle counts. Instead, the stimulus uses short reload values of 1 and 2 and issues back-to-back status reads or periodic current-value writes, so the collisions recur many times. A behavioural model checks each cycle. A reference-tick phase with a sparse strobe pattern and a one-shot phase with reload 0 cover the tick gating and the automatic stop.

// File: rtl/stk_pkg.sv
package stk_pkg;
   // word indices of the register window (byte offset / 4)
   localparam int unsigned WIDX_CTRL   = 4;
   localparam int unsigned WIDX_RELOAD = 5;
   localparam int unsigned WIDX_CUR    = 6;
   localparam int unsigned WIDX_CAL    = 7;

   // control/status field positions
   localparam int unsigned CB_EN   = 0;
   localparam int unsigned CB_IE   = 1;
   localparam int unsigned CB_SRC  = 2;
   localparam int unsigned CB_FLAG = 16;

   typedef enum logic [2:0] {
      RS_NONE,
      RS_CTRL,
      RS_RELOAD,
      RS_CUR,
      RS_CAL
   } rsel_e;

   typedef struct packed {
      logic wr_ctrl;
      logic wr_reload;
      logic wr_cur;
      logic rd_ctrl;
   } strobe_t;
endpackage

// File: rtl/stk_bus_decode.sv
module stk_bus_decode
   import stk_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   output strobe_t           stb,
   output rsel_e             rsel
);
   localparam int unsigned IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0] widx;
   logic             hit_ctrl, hit_reload, hit_cur, hit_cal;
   logic             rd_cyc, wr_cyc;
   logic [1:0]       unused_lsb;

   assign widx       = bus_addr[ADDR_W-1:2];
   assign unused_lsb = bus_addr[1:0];
   assign rd_cyc     = bus_sel & ~bus_wr;
   assign wr_cyc     = bus_sel & bus_wr;

   assign hit_ctrl   = (widx == IDX_W'(WIDX_CTRL));
   assign hit_reload = (widx == IDX_W'(WIDX_RELOAD));
   assign hit_cur    = (widx == IDX_W'(WIDX_CUR));
   assign hit_cal    = (widx == IDX_W'(WIDX_CAL));

   assign stb.wr_ctrl   = wr_cyc & hit_ctrl;
   assign stb.wr_reload = wr_cyc & hit_reload;
   assign stb.wr_cur    = wr_cyc & hit_cur;
   assign stb.rd_ctrl   = rd_cyc & hit_ctrl;

   always_comb begin
      rsel = RS_NONE;
      if (rd_cyc) begin
         if (hit_ctrl)        rsel = RS_CTRL;
         else if (hit_reload) rsel = RS_RELOAD;
         else if (hit_cur)    rsel = RS_CUR;
         else if (hit_cal)    rsel = RS_CAL;
      end
   end
endmodule

// File: rtl/stk_ctrl_regs.sv
module stk_ctrl_regs
   import stk_pkg::*;
#(
   parameter int unsigned CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  strobe_t          stb,
   input  logic [2:0]       ctrl_wdata,
   input  logic [CNT_W-1:0] reload_wdata,
   input  logic             expire,
   output logic             en,
   output logic             tick_ie,
   output logic             src_core,
   output logic             flag,
   output logic [CNT_W-1:0] reload,
   output logic             src_chg,
   output logic             en_rise
);
   logic reload_zero;

   assign reload_zero = (reload == '0);
   assign src_chg     = stb.wr_ctrl & (ctrl_wdata[CB_SRC] != src_core);
   assign en_rise     = stb.wr_ctrl & ctrl_wdata[CB_EN] & ~en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en       <= 1'b0;
         tick_ie  <= 1'b0;
         src_core <= 1'b0;
      end else if (stb.wr_ctrl) begin
         en       <= ctrl_wdata[CB_EN];
         tick_ie  <= ctrl_wdata[CB_IE];
         src_core <= ctrl_wdata[CB_SRC];
      end else if (expire && reload_zero) begin
         en       <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            flag <= 1'b0;
      else if (stb.wr_cur)   flag <= 1'b0;
      else if (expire)       flag <= 1'b1;
      else if (stb.rd_ctrl)  flag <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              reload <= '0;
      else if (stb.wr_reload)  reload <= reload_wdata;
   end

   // R5
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> flag);
   // R3
   flag_rdclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stb.rd_ctrl && !expire) |=> !flag);
   // R6
   oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && reload_zero && !stb.wr_ctrl) |=> !en);
   // R2
   ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb.wr_ctrl |=> (en == $past(ctrl_wdata[CB_EN])) && (src_core == $past(ctrl_wdata[CB_SRC])));
endmodule

// File: rtl/stk_down_counter.sv
module stk_down_counter #(
   parameter int unsigned CNT_W          = 24,
   parameter bit          REF_REGISTERED = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             src_core,
   input  logic             ref_tick_en,
   input  logic [CNT_W-1:0] reload,
   input  logic             wr_cur,
   input  logic             src_chg,
   input  logic             en_rise,
   output logic [CNT_W-1:0] cnt,
   output logic             expire
);
   logic ref_step;
   logic tick;
   logic cnt_zero;
   logic load;

   generate
      if (REF_REGISTERED) begin : g_ref_reg
         logic ref_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ref_q <= 1'b0;
            else        ref_q <= ref_tick_en;
         end
         assign ref_step = ref_q;
      end else begin : g_ref_direct
         assign ref_step = ref_tick_en;
      end
   endgenerate

   assign tick     = en & (src_core | ref_step);
   assign cnt_zero = (cnt == '0);
   assign load     = wr_cur | src_chg | (en_rise & cnt_zero);
   assign expire   = tick & cnt_zero & ~wr_cur & ~src_chg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (load)     cnt <= reload;
      else if (tick) begin
         if (cnt_zero)   cnt <= reload;
         else            cnt <= cnt - 1'b1;
      end
   end

   // R7
   cur_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cur |=> (cnt == $past(reload)));
   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(cnt));
   // R4
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_zero && !load) |=> (cnt == $past(cnt) - 1'b1));
   // R9
   src_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_chg |-> !expire);
endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
   import stk_pkg::*;
#(
   parameter int unsigned ADDR_W         = 8,
   parameter int unsigned CNT_W          = 24,
   parameter logic [31:0] CALIB_VALUE    = 32'h0000_2710,
   parameter bit          REF_REGISTERED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick_en,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq_pend
);
   generate
      if (ADDR_W < 5) begin : g_bad_addr
         $error("ADDR_W must cover offset 0x1C");
      end
      if (CNT_W < 2 || CNT_W > 31) begin : g_bad_cnt
         $error("CNT_W must lie in 2..31");
      end
   endgenerate

   strobe_t          stb;
   rsel_e            rsel;
   logic             en, tick_ie, src_core, flag;
   logic [CNT_W-1:0] reload, cnt;
   logic             src_chg, en_rise, expire;
   logic             irq_q;
   logic [31:0]      ctrl_word;
   logic             unused_wbits;

   assign unused_wbits = ^bus_wdata[31:CNT_W];

   stk_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
      .bus_sel (bus_sel),
      .bus_wr  (bus_wr),
      .bus_addr(bus_addr),
      .stb     (stb),
      .rsel    (rsel)
   );

   stk_ctrl_regs #(.CNT_W(CNT_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .stb         (stb),
      .ctrl_wdata  (bus_wdata[2:0]),
      .reload_wdata(bus_wdata[CNT_W-1:0]),
      .expire      (expire),
      .en          (en),
      .tick_ie     (tick_ie),
      .src_core    (src_core),
      .flag        (flag),
      .reload      (reload),
      .src_chg     (src_chg),
      .en_rise     (en_rise)
   );

   stk_down_counter #(.CNT_W(CNT_W), .REF_REGISTERED(REF_REGISTERED)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .src_core   (src_core),
      .ref_tick_en(ref_tick_en),
      .reload     (reload),
      .wr_cur     (stb.wr_cur),
      .src_chg    (src_chg),
      .en_rise    (en_rise),
      .cnt        (cnt),
      .expire     (expire)
   );

   always_comb begin
      ctrl_word          = '0;
      ctrl_word[CB_EN]   = en;
      ctrl_word[CB_IE]   = tick_ie;
      ctrl_word[CB_SRC]  = src_core;
      ctrl_word[CB_FLAG] = flag;
   end

   always_comb begin
      unique case (rsel)
         RS_CTRL:   bus_rdata = ctrl_word;
         RS_RELOAD: bus_rdata = 32'(reload);
         RS_CUR:    bus_rdata = en ? 32'(cnt) : 32'd0;
         RS_CAL:    bus_rdata = CALIB_VALUE;
         default:   bus_rdata = 32'd0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= expire & tick_ie;
   end
   assign irq_pend = irq_q;

   // R5
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pend |-> $past(tick_ie) && flag);
endmodule

// File: tb/test_sys_tick_timer.sv
module test_sys_tick_timer;
   localparam logic [31:0] CALIB = 32'h0000_2710;
   localparam int unsigned MASK  = 32'h00FF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_tick_en = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_pend;

   always #5 clk = ~clk;

   sys_tick_timer i_sys_tick_timer (
      .clk(clk), .rst_n(rst_n), .ref_tick_en(ref_tick_en),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pend(irq_pend)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // behavioural reference state
   int unsigned m_cnt = 0, m_reload = 0;
   bit m_en = 0, m_ie = 0, m_src = 0, m_flag = 0, m_irq = 0;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] model_read(logic [7:0] a);
      case (a)
         8'h10: return (32'(m_flag) << 16) | (32'(m_src) << 2) | (32'(m_ie) << 1) | 32'(m_en);
         8'h14: return m_reload;
         8'h18: return m_en ? m_cnt : 32'd0;
         8'h1C: return CALIB;
         default: return 32'd0;
      endcase
   endfunction

   task automatic cyc(bit sel, bit wr, logic [7:0] a, logic [31:0] d, bit rt);
      bit wc, wrl, wcur, rc, tick, schg, erise, exp_ev;
      string tag;
      @(negedge clk);
      bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d; ref_tick_en = rt;
      #1;
      chk("R5 irq_pend", 32'(irq_pend), 32'(m_irq));
      if (sel && !wr) begin
         case (a)
            8'h10: tag = "R3 ctrl read";
            8'h14: tag = "R10 reload read";
            8'h18: tag = "R8 current read";
            8'h1C: tag = "R11 calib read";
            default: tag = "R12 unmapped read";
         endcase
         chk(tag, bus_rdata, model_read(a));
      end
      wc    = sel && wr && a == 8'h10;
      wrl   = sel && wr && a == 8'h14;
      wcur  = sel && wr && a == 8'h18;
      rc    = sel && !wr && a == 8'h10;
      tick  = m_en && (m_src || rt);
      schg  = wc && (d[2] != m_src);
      erise = wc && d[0] && !m_en && m_cnt == 0;
      exp_ev = tick && m_cnt == 0 && !wcur && !schg;
      m_irq = exp_ev && m_ie;
      if (wcur) m_flag = 0; else if (exp_ev) m_flag = 1; else if (rc) m_flag = 0;
      if (wcur || schg || erise) m_cnt = m_reload;
      else if (tick) m_cnt = (m_cnt == 0) ? m_reload : m_cnt - 1;
      if (wc) begin m_en = d[0]; m_ie = d[1]; m_src = d[2]; end
      else if (exp_ev && m_reload == 0) m_en = 0;
      if (wrl) m_reload = d & MASK;
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d); cyc(1, 1, a, d, 0); endtask
   task automatic rd(logic [7:0] a); cyc(1, 0, a, 0, 0); endtask
   task automatic idle(int n, int ref_every);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, ref_every != 0 && (i % ref_every) == 0);
   endtask

   initial begin
      #200000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state against literal values
      rd(8'h10); chk("R1 ctrl after reset", bus_rdata, 32'h0);
      rd(8'h14); chk("R1 reload after reset", bus_rdata, 32'h0);
      rd(8'h18); chk("R1 current after reset", bus_rdata, 32'h0);
      rd(8'h1C); chk("R1 calib after reset", bus_rdata, CALIB);
      chk("R1 irq after reset", 32'(irq_pend), 32'h0);
      // R10 upper bits dropped
      wr(8'h14, 32'hFFFF_FFFF); rd(8'h14); chk("R10 reload width", bus_rdata, 32'h00FF_FFFF);
      // R11 calib read-only, R12 unmapped offset
      wr(8'h1C, 32'h1234_5678); rd(8'h1C); chk("R11 calib unchanged", bus_rdata, CALIB);
      wr(8'h20, 32'hA5A5_A5A5); rd(8'h20); chk("R12 unmapped reads 0", bus_rdata, 32'h0);
      rd(8'h14); chk("R12 reload untouched", bus_rdata, 32'h00FF_FFFF);
      // periodic on core clock, R4 R5 R7
      wr(8'h14, 4); wr(8'h18, 32'hDEAD_BEEF); wr(8'h10, 7);
      idle(22, 0);
      rd(8'h10); rd(8'h10); rd(8'h18); rd(8'h18);
      // R2 upper bits of control ignored
      wr(8'h10, 32'hFFFE_FFFF & 32'hFFFF_FFF7); rd(8'h10);
      // R8 pause and resume
      idle(2, 0);
      wr(8'h10, 6); rd(8'h18); chk("R8 disabled current reads 0", bus_rdata, 32'h0);
      idle(5, 0); wr(8'h10, 7); rd(8'h18); idle(3, 0); rd(8'h18);
      // R9 source change to reference tick, R4 gating
      wr(8'h10, 3); rd(8'h18);
      idle(30, 3); rd(8'h10); idle(12, 4); rd(8'h18);
      wr(8'h10, 7);
      // R3 status reads colliding with expiry, reload 2
      wr(8'h14, 2); wr(8'h18, 0);
      for (int i = 0; i < 12; i++) rd(8'h10);
      // R7 current writes colliding with expiry
      for (int i = 0; i < 6; i++) begin wr(8'h18, 32'(i)); idle(2, 0); end
      rd(8'h10);
      wr(8'h14, 1);
      for (int i = 0; i < 5; i++) begin wr(8'h18, 0); idle(1, 0); rd(8'h10); end
      // R6 one-shot: reload 0 stops the timer
      wr(8'h14, 0); wr(8'h18, 0); idle(4, 0);
      rd(8'h10); chk("R6 enable cleared after one-shot", bus_rdata & 32'h1, 32'h0);
      rd(8'h18); chk("R6 current reads 0 after stop", bus_rdata, 32'h0);
      // R8 enable with counter at 0 loads reload
      wr(8'h14, 5); wr(8'h10, 7); rd(8'h18); idle(8, 0); rd(8'h18);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule